// File: doc/BRIEF.md
# Flash Cycle Sequencer with Register Port

This block lets software run single flash accesses through four registers on a simple synchronous register port. Software loads a linear byte address and, for writes, the data to program. It then writes the control register with a cycle type, a byte count and the go bit set. When the request is valid, the sequencer raises a request on a plain backing flash port and holds it until the flash acknowledges. It then loads read data into the data register, least significant byte first, and reports the result in the status register.

The linear address is masked to `ADDR_W` bits and offset by `FLASH_BASE` before it reaches the flash port. Some requests are refused and set an error flag without touching the flash: a go while a cycle runs, a go while the descriptor-valid strap is low, a go with the reserved cycle type, and a go with an address above the mask. Status flags are write-one-to-clear.

The cycle engine has three states. `SQ_IDLE` moves to `SQ_WAIT` on an accepted launch. `SQ_WAIT` drives the flash request and moves to `SQ_FINISH` when the flash acknowledges. `SQ_FINISH` raises the done flag, the error flag if the flash reported a failure, and the read-data load, then returns to `SQ_IDLE`.

Top module: `flash_cycle_seq`

## Requirements
- R1: After reset the status register reads only the descriptor-valid bit (bit 14, which mirrors `desc_valid`), and the control, address and data registers read 0.
- R2: `reg_sel` selects 0 status, 1 control, 2 address and 3 data. Status bits are: done at bit 0, cycle error at 1, access error at 2, in progress at 5, descriptor valid at 14. Control bits are: go at bit 0 (always reads 0), cycle type at 2:1, byte count at 8.
- R3: An accepted go clears done and sets in-progress one clock later. In-progress stays set until the cycle finishes, and done is set two clocks after the flash acknowledge.
- R4: A read cycle (type 00) loads the data register LSB first. With byte count 0 it holds the byte at the address in bits 7:0. With byte count 1 it also holds the next byte in bits 15:8. All higher bits are zero. `fl_rdata[7:0]` carries the byte at `fl_addr`.
- R5: `fl_addr` equals the linear address ANDed with 2^ADDR_W−1, plus `FLASH_BASE`. A go with a linear address above that mask sets the access-error bit and makes no flash access.
- R6: A write cycle (type 10) drives `fl_wdata` from the data register: the low byte when the byte count is 0 (upper byte zero), both low bytes when it is 1. `fl_size` equals the byte count. A sector erase (type 11) drives `fl_op` = 11. `fl_op` always carries the cycle type.
- R7: A flash acknowledge with `fl_err` high sets both the done and cycle-error bits and leaves the data register unchanged.
- R8: Writing 1 to status bits 0, 1 or 2 clears that bit. Writing 0 leaves it unchanged. In-progress and descriptor-valid ignore writes.
- R9: A go while a cycle runs, while `desc_valid` is 0, or with cycle type 01 makes no flash access and sets the cycle-error bit.
- R10: Writes to the control, address and data registers while a cycle is in progress are ignored.
- R11: `fl_req` stays high with stable address, operation, size and write data until `fl_ack`. Each accepted go produces exactly one request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| desc_valid | input | 1 | Descriptor-valid strap |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on `reg_sel`) |
| fl_req | output | 1 | Flash access request |
| fl_op | output | 2 | Flash operation: 00 read, 10 write, 11 erase |
| fl_addr | output | 32 | Flash byte address |
| fl_size | output | 1 | 0 for one byte, 1 for two bytes |
| fl_wdata | output | 16 | Write data, LSB first |
| fl_ack | input | 1 | Flash access complete |
| fl_err | input | 1 | Flash access failed (valid with `fl_ack`) |
| fl_rdata | input | 16 | Read data (valid with `fl_ack`) |

## Verification
The bench sweeps read and write cycles across the address space at both byte counts. A design that packs bytes in the wrong order, or leaks the second byte into a one-byte read, returns a wrong data word. It also catches a one-byte write that corrupts the neighbouring byte. Addresses one past the mask are tried to catch a design that wraps them instead of flagging an access error. A second go is issued the cycle after a launch, along with address writes mid-cycle, to catch a design that issues a duplicate access or lets the address change under a running cycle. Flash failures, the reserved cycle type, a low descriptor strap and write-one-to-clear with mixed bit patterns are each checked. A design that mixes up the error flags or clears the wrong bit shows it in the status word.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [1:0] {
        SQ_IDLE   = 2'd0,
        SQ_WAIT   = 2'd1,
        SQ_FINISH = 2'd2
    } sq_state_e;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_RSVD  = 2'b01,
        OP_WRITE = 2'b10,
        OP_ERASE = 2'b11
    } fl_op_e;

    localparam logic [1:0] SEL_STS  = 2'd0;
    localparam logic [1:0] SEL_CTL  = 2'd1;
    localparam logic [1:0] SEL_ADDR = 2'd2;
    localparam logic [1:0] SEL_DATA = 2'd3;

    localparam int STS_DONE = 0;
    localparam int STS_CERR = 1;
    localparam int STS_AERR = 2;
    localparam int STS_BUSY = 5;
    localparam int STS_DESC = 14;

    localparam int CTL_GO   = 0;
    localparam int CTL_TYLO = 1;
    localparam int CTL_TYHI = 2;
    localparam int CTL_BCNT = 8;

endpackage

// File: rtl/flash_seq_launch.sv
module flash_seq_launch
    import flash_seq_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter logic [31:0] FLASH_BASE = 32'h0000_0100
) (
    input  logic        go_wr,
    input  fl_op_e      go_op,
    input  logic        busy,
    input  logic        desc_valid,
    input  logic [31:0] lin_addr,
    output logic        launch,
    output logic        rej_cycle,
    output logic        rej_addr,
    output logic [31:0] phys_addr
);
    localparam logic [31:0] LIN_MASK = (32'h1 << ADDR_W) - 32'h1;

    logic bad_type;
    logic out_of_range;

    always_comb begin
        bad_type     = (go_op == OP_RSVD);
        out_of_range = (lin_addr > LIN_MASK);
        rej_cycle    = go_wr && (busy || !desc_valid || bad_type);
        rej_addr     = go_wr && !rej_cycle && out_of_range;
        launch       = go_wr && !rej_cycle && !out_of_range;
        phys_addr    = (lin_addr & LIN_MASK) + FLASH_BASE;
    end
endmodule

// File: rtl/flash_seq_fsm.sv
module flash_seq_fsm
    import flash_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        launch,
    input  fl_op_e      launch_op,
    input  logic        launch_bcnt,
    input  logic [31:0] launch_addr,
    input  logic [15:0] launch_wdata,
    input  logic        fl_ack,
    input  logic        fl_err,
    input  logic [15:0] fl_rdata,
    output logic        fl_req,
    output fl_op_e      fl_op,
    output logic [31:0] fl_addr,
    output logic        fl_size,
    output logic [15:0] fl_wdata,
    output logic        busy,
    output logic        cyc_done,
    output logic        cyc_fail,
    output logic        rd_load,
    output logic [31:0] rd_word
);
    sq_state_e   state_q, state_d;
    fl_op_e      op_q;
    logic        bcnt_q;
    logic [31:0] addr_q;
    logic [15:0] wdat_q;
    logic        err_q;
    logic [15:0] rdat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:   if (launch) state_d = SQ_WAIT;
            SQ_WAIT:   if (fl_ack) state_d = SQ_FINISH;
            SQ_FINISH: state_d = SQ_IDLE;
            default:   state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q   <= OP_READ;
            bcnt_q <= 1'b0;
            addr_q <= '0;
            wdat_q <= '0;
            err_q  <= 1'b0;
            rdat_q <= '0;
        end else begin
            if (state_q == SQ_IDLE && launch) begin
                op_q   <= launch_op;
                bcnt_q <= launch_bcnt;
                addr_q <= launch_addr;
                wdat_q <= launch_bcnt ? launch_wdata : {8'h00, launch_wdata[7:0]};
            end
            if (state_q == SQ_WAIT && fl_ack) begin
                err_q  <= fl_err;
                rdat_q <= fl_rdata;
            end
        end
    end

    always_comb begin
        fl_req   = 1'b0;
        busy     = 1'b1;
        cyc_done = 1'b0;
        cyc_fail = 1'b0;
        rd_load  = 1'b0;
        unique case (state_q)
            SQ_IDLE:   busy = 1'b0;
            SQ_WAIT:   fl_req = 1'b1;
            SQ_FINISH: begin
                cyc_done = 1'b1;
                cyc_fail = err_q;
                rd_load  = (op_q == OP_READ) && !err_q;
            end
            default:   busy = 1'b0;
        endcase
        fl_op    = op_q;
        fl_addr  = addr_q;
        fl_size  = bcnt_q;
        fl_wdata = wdat_q;
        rd_word  = bcnt_q ? {16'h0000, rdat_q} : {24'h000000, rdat_q[7:0]};
    end
endmodule

// File: rtl/flash_seq_status.sv
module flash_seq_status
    import flash_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sts_wr,
    input  logic [2:0]  clr_bits,
    input  logic        launch,
    input  logic        cyc_done,
    input  logic        cyc_fail,
    input  logic        rej_cycle,
    input  logic        rej_addr,
    input  logic        busy,
    input  logic        desc_valid,
    output logic [15:0] sts_word
);
    logic done_q, cerr_q, aerr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            cerr_q <= 1'b0;
            aerr_q <= 1'b0;
        end else begin
            if (cyc_done)                     done_q <= 1'b1;
            else if (launch)                  done_q <= 1'b0;
            else if (sts_wr && clr_bits[0])   done_q <= 1'b0;

            if (cyc_fail || rej_cycle)        cerr_q <= 1'b1;
            else if (sts_wr && clr_bits[1])   cerr_q <= 1'b0;

            if (rej_addr)                     aerr_q <= 1'b1;
            else if (sts_wr && clr_bits[2])   aerr_q <= 1'b0;
        end
    end

    always_comb begin
        sts_word           = '0;
        sts_word[STS_DONE] = done_q;
        sts_word[STS_CERR] = cerr_q;
        sts_word[STS_AERR] = aerr_q;
        sts_word[STS_BUSY] = busy;
        sts_word[STS_DESC] = desc_valid;
    end
endmodule

// File: rtl/flash_cycle_seq.sv
module flash_cycle_seq
    import flash_seq_pkg::*;
#(
    parameter int          ADDR_W     = 8,
    parameter logic [31:0] FLASH_BASE = 32'h0000_0100
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        desc_valid,
    input  logic        reg_wr,
    input  logic [1:0]  reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        fl_req,
    output logic [1:0]  fl_op,
    output logic [31:0] fl_addr,
    output logic        fl_size,
    output logic [15:0] fl_wdata,
    input  logic        fl_ack,
    input  logic        fl_err,
    input  logic [15:0] fl_rdata
);
    fl_op_e      ctl_type_q;
    logic        ctl_bcnt_q;
    logic [31:0] addr_q;
    logic [31:0] data_q;

    logic        busy, launch, rej_cycle, rej_addr;
    logic        cyc_done, cyc_fail, rd_load;
    logic [31:0] phys_addr, rd_word;
    logic [15:0] sts_word;
    fl_op_e      go_op, fl_op_e_w;
    logic        ctl_wr, go_wr, sts_wr, addr_wr, data_wr;

    always_comb begin
        sts_wr  = reg_wr && (reg_sel == SEL_STS);
        ctl_wr  = reg_wr && (reg_sel == SEL_CTL);
        addr_wr = reg_wr && (reg_sel == SEL_ADDR) && !busy;
        data_wr = reg_wr && (reg_sel == SEL_DATA) && !busy;
        go_wr   = ctl_wr && reg_wdata[CTL_GO];
        go_op   = fl_op_e'(reg_wdata[CTL_TYHI:CTL_TYLO]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_type_q <= OP_READ;
            ctl_bcnt_q <= 1'b0;
            addr_q     <= '0;
            data_q     <= '0;
        end else begin
            if (ctl_wr && !busy) begin
                ctl_type_q <= go_op;
                ctl_bcnt_q <= reg_wdata[CTL_BCNT];
            end
            if (addr_wr) addr_q <= reg_wdata;
            if (rd_load)      data_q <= rd_word;
            else if (data_wr) data_q <= reg_wdata;
        end
    end

    flash_seq_launch #(
        .ADDR_W     (ADDR_W),
        .FLASH_BASE (FLASH_BASE)
    ) u_launch (
        .go_wr      (go_wr),
        .go_op      (go_op),
        .busy       (busy),
        .desc_valid (desc_valid),
        .lin_addr   (addr_q),
        .launch     (launch),
        .rej_cycle  (rej_cycle),
        .rej_addr   (rej_addr),
        .phys_addr  (phys_addr)
    );

    flash_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .launch       (launch),
        .launch_op    (go_op),
        .launch_bcnt  (reg_wdata[CTL_BCNT]),
        .launch_addr  (phys_addr),
        .launch_wdata (data_q[15:0]),
        .fl_ack       (fl_ack),
        .fl_err       (fl_err),
        .fl_rdata     (fl_rdata),
        .fl_req       (fl_req),
        .fl_op        (fl_op_e_w),
        .fl_addr      (fl_addr),
        .fl_size      (fl_size),
        .fl_wdata     (fl_wdata),
        .busy         (busy),
        .cyc_done     (cyc_done),
        .cyc_fail     (cyc_fail),
        .rd_load      (rd_load),
        .rd_word      (rd_word)
    );

    flash_seq_status u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .sts_wr     (sts_wr),
        .clr_bits   (reg_wdata[2:0]),
        .launch     (launch),
        .cyc_done   (cyc_done),
        .cyc_fail   (cyc_fail),
        .rej_cycle  (rej_cycle),
        .rej_addr   (rej_addr),
        .busy       (busy),
        .desc_valid (desc_valid),
        .sts_word   (sts_word)
    );

    always_comb begin
        fl_op = fl_op_e_w;
        unique case (reg_sel)
            SEL_STS:  reg_rdata = {16'h0000, sts_word};
            SEL_CTL:  reg_rdata = {23'h0, ctl_bcnt_q, 5'h0, ctl_type_q, 1'b0};
            SEL_ADDR: reg_rdata = addr_q;
            SEL_DATA: reg_rdata = data_q;
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/flash_seq_checker.sv
module flash_seq_checker #(
    parameter int          ADDR_W     = 8,
    parameter logic [31:0] FLASH_BASE = 32'h0000_0100
) (
    input logic        clk,
    input logic        rst_n,
    input logic        desc_valid,
    input logic        fl_req,
    input logic        fl_ack,
    input logic [1:0]  fl_op,
    input logic [31:0] fl_addr,
    input logic        fl_size,
    input logic [15:0] fl_wdata,
    input logic [15:0] sts_word
);
    localparam logic [31:0] LIN_MASK = (32'h1 << ADDR_W) - 32'h1;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && !fl_ack) |=> (fl_req && $stable(fl_addr) && $stable(fl_op)
                                 && $stable(fl_size) && $stable(fl_wdata))); // R11

    AST_BUSY_DURING_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req |-> sts_word[5]); // R3

    AST_NO_LAUNCH_BAD_DESC: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fl_req) |-> $past(desc_valid)); // R9

    AST_ADDR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req |-> (fl_addr >= FLASH_BASE && (fl_addr - FLASH_BASE) <= LIN_MASK)); // R5

    AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_req && fl_ack) |=> ##1 sts_word[0]); // R3

    AST_NO_RSVD_OP: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req |-> (fl_op != 2'b01)); // R9
endmodule

bind flash_cycle_seq flash_seq_checker #(
    .ADDR_W     (ADDR_W),
    .FLASH_BASE (FLASH_BASE)
) u_flash_seq_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .desc_valid (desc_valid),
    .fl_req     (fl_req),
    .fl_ack     (fl_ack),
    .fl_op      (fl_op),
    .fl_addr    (fl_addr),
    .fl_size    (fl_size),
    .fl_wdata   (fl_wdata),
    .sts_word   (sts_word)
);

// File: tb/test_flash_cycle_seq.sv
module test_flash_cycle_seq;
    localparam logic [31:0] BASE = 32'h0000_0100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        desc_valid = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        fl_req, fl_size;
    logic [1:0]  fl_op;
    logic [31:0] fl_addr;
    logic [15:0] fl_wdata;
    logic        fl_ack = 1'b0;
    logic        fl_err = 1'b0;
    logic [15:0] fl_rdata = '0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [7:0]  mem [256];
    int          lat = 1;
    bit          inject_err = 0;
    int          wait_cnt = 0;
    int          req_count = 0;
    logic        req_prev = 1'b0;
    logic [31:0] obs_addr;
    logic [1:0]  obs_op;
    logic        obs_size;

    flash_cycle_seq i_flash_cycle_seq (
        .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fl_req(fl_req), .fl_op(fl_op), .fl_addr(fl_addr), .fl_size(fl_size),
        .fl_wdata(fl_wdata), .fl_ack(fl_ack), .fl_err(fl_err), .fl_rdata(fl_rdata)
    );

    always #4 clk = ~clk;

    // Flash model
    always @(posedge clk) begin
        req_prev <= fl_req;
        if (fl_req && !req_prev) req_count <= req_count + 1;
        if (fl_req && !fl_ack) begin
            if (wait_cnt >= lat) begin
                automatic int a = int'(fl_addr - BASE) & 255;
                fl_ack   <= 1'b1;
                fl_err   <= inject_err;
                fl_rdata <= {mem[(a + 1) & 255], mem[a]};
                obs_addr <= fl_addr;
                obs_op   <= fl_op;
                obs_size <= fl_size;
                if (!inject_err) begin
                    if (fl_op == 2'b10) begin
                        mem[a] <= fl_wdata[7:0];
                        if (fl_size) mem[(a + 1) & 255] <= fl_wdata[15:8];
                    end else if (fl_op == 2'b11) begin
                        mem[a] <= 8'hFF;
                    end
                end
                wait_cnt <= 0;
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end else begin
            fl_ack <= 1'b0;
            fl_err <= 1'b0;
        end
    end

    function automatic logic [7:0] pat(int a);
        return 8'((a * 37 + 5) & 255);
    endfunction

    task automatic fill_mem();
        for (int i = 0; i < 256; i++) mem[i] = pat(i);
    endtask

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(logic [1:0] sel, logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic bus_rd(logic [1:0] sel, output logic [31:0] d);
        @(negedge clk);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    task automatic wait_done(output bit ok);
        logic [31:0] s;
        ok = 0;
        for (int i = 0; i < 200; i++) begin
            bus_rd(2'd0, s);
            if (s[0] && !s[5]) begin ok = 1; break; end
        end
    endtask

    task automatic run_cycle(int a, logic [1:0] ty, logic bc, output bit ok);
        bus_wr(2'd0, 32'h7);
        bus_wr(2'd2, 32'(a));
        bus_wr(2'd1, {23'h0, bc, 5'h0, ty, 1'b1});
        wait_done(ok);
    endtask

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        bit ok;
        int rc;
        fill_mem();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        bus_rd(2'd0, r); chk(r == 32'h4000, "R1 status", r, 32'h4000);
        bus_rd(2'd1, r); chk(r == 0, "R1 control", r, 0);
        bus_rd(2'd2, r); chk(r == 0, "R1 address", r, 0);
        bus_rd(2'd3, r); chk(r == 0, "R1 data", r, 0);

        // R4 R5 read sweep, both byte counts
        for (int a = 0; a < 255; a += 5) begin
            for (int bc = 0; bc < 2; bc++) begin
                automatic logic [31:0] exp = bc ? {16'h0, pat(a + 1), pat(a)} : {24'h0, pat(a)};
                lat = a % 4;
                run_cycle(a, 2'b00, bc[0], ok);
                chk(ok, "R3 read done", 32'(ok), 1);
                bus_rd(2'd3, r); chk(r == exp, "R4 read data", r, exp);
                chk(obs_addr == BASE + 32'(a), "R5 address", obs_addr, BASE + 32'(a));
                chk(obs_size == bc[0], "R6 size", 32'(obs_size), 32'(bc));
                bus_rd(2'd0, r); chk(r[2:0] == 3'b001, "R3 status flags", r, 32'h4001);
            end
        end
        // R2 control readback (go reads 0)
        bus_rd(2'd1, r); chk(r == 32'h100, "R2 control", r, 32'h100);

        // R6 write sweep
        for (int a = 3; a < 250; a += 17) begin
            for (int bc = 0; bc < 2; bc++) begin
                automatic logic [15:0] v = 16'hA55A ^ 16'(a * 13);
                fill_mem();
                lat = bc + 1;
                bus_wr(2'd3, {16'h0, v});
                run_cycle(a, 2'b10, bc[0], ok);
                chk(obs_op == 2'b10, "R6 op write", 32'(obs_op), 2);
                chk(mem[a] == v[7:0], "R6 low byte", 32'(mem[a]), 32'(v[7:0]));
                if (bc == 1)
                    chk(mem[a + 1] == v[15:8], "R6 high byte", 32'(mem[a + 1]), 32'(v[15:8]));
                else
                    chk(mem[a + 1] == pat(a + 1), "R6 neighbour kept", 32'(mem[a + 1]), 32'(pat(a + 1)));
            end
        end

        // R6 erase
        fill_mem();
        run_cycle(40, 2'b11, 1'b0, ok);
        chk(obs_op == 2'b11 && mem[40] == 8'hFF, "R6 erase", 32'(obs_op), 3);

        // R7 flash failure
        bus_wr(2'd3, 32'h1234_5678);
        inject_err = 1;
        run_cycle(10, 2'b00, 1'b1, ok);
        inject_err = 0;
        bus_rd(2'd0, r); chk(r[2:0] == 3'b011, "R7 status", r, 32'h4003);
        bus_rd(2'd3, r); chk(r == 32'h1234_5678, "R7 data kept", r, 32'h1234_5678);

        // R8 write-one-to-clear
        bus_wr(2'd0, 32'h0000_0000);
        bus_rd(2'd0, r); chk(r == 32'h4003, "R8 zero write", r, 32'h4003);
        bus_wr(2'd0, 32'h0000_4022);
        bus_rd(2'd0, r); chk(r == 32'h4001, "R8 clear cerr", r, 32'h4001);
        bus_wr(2'd0, 32'h0000_0001);
        bus_rd(2'd0, r); chk(r == 32'h4000, "R8 clear done", r, 32'h4000);

        // R5 out of range
        rc = req_count;
        bus_wr(2'd2, 32'h100);
        bus_wr(2'd1, 32'h1);
        repeat (4) @(negedge clk);
        bus_rd(2'd0, r); chk(r == 32'h4004, "R5 access error", r, 32'h4004);
        chk(req_count == rc, "R5 no access", 32'(req_count), 32'(rc));
        bus_wr(2'd0, 32'h4);

        // R9 descriptor invalid
        bus_wr(2'd2, 32'h20);
        desc_valid = 1'b0;
        bus_wr(2'd1, 32'h1);
        repeat (4) @(negedge clk);
        bus_rd(2'd0, r); chk(r == 32'h0002, "R9 desc invalid", r, 32'h0002);
        chk(req_count == rc, "R9 no access desc", 32'(req_count), 32'(rc));
        desc_valid = 1'b1;
        bus_wr(2'd0, 32'h2);

        // R9 reserved type
        bus_wr(2'd1, 32'h3);
        repeat (4) @(negedge clk);
        bus_rd(2'd0, r); chk(r == 32'h4002, "R9 reserved type", r, 32'h4002);
        chk(req_count == rc, "R9 no access rsvd", 32'(req_count), 32'(rc));
        bus_wr(2'd0, 32'h2);

        // R3 R9 R10 R11 go while busy, register writes mid-cycle
        lat = 20;
        bus_wr(2'd0, 32'h0);
        bus_wr(2'd2, 32'h30);
        run_cycle(48, 2'b00, 1'b0, ok);      // done left set
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 32'h1;   // launch
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 2'd1; reg_wdata = 32'h105; // go while busy
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 2'd2; reg_wdata = 32'h77;
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 2'd3; reg_wdata = 32'hDEAD;
        @(negedge clk);
        reg_wr = 1'b0;
        bus_rd(2'd0, r); chk(r[5] && !r[0] && r[1], "R3 busy, done cleared, R9 cerr", r, 32'h4022);
        bus_rd(2'd2, r); chk(r == 32'h30, "R10 address kept", r, 32'h30);
        bus_rd(2'd1, r); chk(r == 32'h0, "R10 control kept", r, 0);
        wait_done(ok);
        chk(ok, "R3 done after busy", 32'(ok), 1);
        chk(req_count == rc + 2, "R11 one request per go", 32'(req_count), 32'(rc + 2));
        bus_rd(2'd3, r); chk(r == {24'h0, pat(48)}, "R10 data from read only", r, {24'h0, pat(48)});
        lat = 1;

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule